// File: doc/BRIEF.md
# Three-Phase Complementary PWM Generator

This block produces three pairs of PWM signals, one pair per phase leg of a bridge. All three pairs take their timing from one shared cycle counter and one shared period value. The counter runs in one of two modes. In ramp mode it counts up from zero to the period value and then wraps, which gives edge-aligned pulses. In centred mode it counts up to the period value and then back down, which gives pulses that are symmetric about the turnaround point.

Each phase has three compare thresholds, called *start*, *release* and *second*. Each phase also has an overlap guard. A six-bit commutation mask can switch any single output off. The mask lets the same waveforms be steered for brushless commutation.

The configuration inputs act as a shadow copy. The block copies them into its working registers only when the counter returns to zero, or at any time while the block is stopped. Because of this, a period is never produced with a mix of old and new settings. The block also gives a one-clock cycle-end pulse and, in centred mode, one synchronisation pulse per phase.

Top module: `pwm3_bridge`

## Requirements
- R1: In ramp mode (`centered_mode`=0) the counter steps 0,1,…,P and then returns to 0, where P is the working period. The period is therefore P+1 clocks.
- R2: In ramp mode, output A of a phase is high for the counter values above *start* and up to *release*. The first edge comes after *start*+1 low clocks, and the pulse lasts *release*−*start* clocks. A *start* value above P keeps A low.
- R3: In ramp mode, output B of a phase is high for the counter values above *second*, which gives P−*second* clocks. When the guard is off, *second* may lie below *release*, and then A and B are both high together.
- R4: In centred mode (`centered_mode`=1) the counter climbs from 0 to P and then falls to 1. The next value is 0, where the climb restarts. The period is therefore 2·P clocks.
- R5: In centred mode, output A is high while the counter is below *start* on the climb, and while it is at or below *start* on the fall. For *start* < P this gives 2·*start* clocks per period.
- R6: In centred mode, output B is high while the counter is at or above *second* on the climb, and while the counter plus one is at or above *second* on the fall. For 2 ≤ *second* ≤ P this gives 2·(P−*second*+1) clocks per period.
- R7: In centred mode, `sync_pulse[m]` is high for one clock each time the counter equals the *release* value of phase m, on the climb and again on the fall. In ramp mode it stays low, so in ramp mode *release* only shapes output A.
- R8: `cycle_end` is high for one clock each time the counter equals P. In ramp mode this is the last count of the period. In centred mode it is the turnaround. Every output is registered and reflects the counter value of the previous clock.
- R9: When the overlap guard of a phase is set, output B is held low whenever the compare window of A is open, so A and B are never high together. A has priority.
- R10: Bit 2m of `out_mask` enables `pwm_a[m]` and bit 2m+1 enables `pwm_b[m]`. A 0 bit forces that output low. The guard in R9 uses the compare windows before the mask is applied.
- R11: While `run` is high, changes to the period, mode, thresholds, guards and mask take effect only at the clock where the counter returns to 0. While `run` is low they are loaded on every clock.
- R12: During reset, and one clock after `run` goes low, all outputs are 0 and the counter restarts from 0 in its climbing state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Counter and outputs active when high |
| centered_mode | input | 1 | 0 = ramp, 1 = centred (shadow) |
| period | input | W | Shared period value P (shadow) |
| start_thr | input | NMOD*W | *start* threshold per phase, phase m at bits m*W (shadow) |
| release_thr | input | NMOD*W | *release* threshold per phase (shadow) |
| second_thr | input | NMOD*W | *second* threshold per phase (shadow) |
| guard_en | input | NMOD | Overlap guard per phase (shadow) |
| out_mask | input | 2*NMOD | Output enables: bit 2m = A, bit 2m+1 = B (shadow) |
| pwm_a | output | NMOD | Output A of each phase |
| pwm_b | output | NMOD | Output B of each phase |
| cycle_end | output | 1 | One-clock pulse at counter value P |
| sync_pulse | output | NMOD | Centred-mode pulse when the counter equals *release* |

## Verification
On every cycle, the assertions check the following:
- the counter stays within the working period and wraps or turns around at the right point;
- the period changes only at a return to zero;
- A and B are never high together when the guard was set;
- a masked output stays low;
- sync pulses appear only in centred mode;
- everything is quiet after `run` falls.

The exact pulse widths can only be shown by the bench's scenarios. These cover the two on-time formulas, thresholds above the period, and the overlap count with the guard off and on. They also show that a mid-period change of mask or thresholds is deferred to the next period, which the bench's cycle-accurate model compares on every clock.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;

  typedef enum logic {
    MODE_RAMP   = 1'b0,
    MODE_CENTER = 1'b1
  } cnt_mode_e;

endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm3_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  cnt_mode_e    mode_in,
  input  logic [W-1:0] period_in,
  output logic [W-1:0] cnt_q,
  output logic         up_q,
  output cnt_mode_e    mode_q,
  output logic         load,
  output logic         eoc_q
);

  logic [W-1:0] rb_q;
  logic [W-1:0] cnt_nxt;
  logic         up_nxt;
  logic         eoc_nxt;

  // next counter state
  always_comb begin
    cnt_nxt = cnt_q;
    up_nxt  = up_q;
    if (!run) begin
      cnt_nxt = '0;
      up_nxt  = 1'b1;
    end else if (mode_q == MODE_RAMP) begin
      cnt_nxt = (cnt_q == rb_q) ? '0 : cnt_q + 1'b1;
      up_nxt  = 1'b1;
    end else if (up_q) begin
      if (cnt_q >= rb_q) begin
        up_nxt  = 1'b0;
        cnt_nxt = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
      end else begin
        cnt_nxt = cnt_q + 1'b1;
      end
    end else begin
      cnt_nxt = (cnt_q <= W'(1)) ? '0 : cnt_q - 1'b1;
      up_nxt  = 1'b0;
    end
    if (cnt_nxt == '0) up_nxt = 1'b1;
  end

  assign load    = !run || (cnt_nxt == '0);
  assign eoc_nxt = run && (cnt_q == rb_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      up_q   <= 1'b1;
      rb_q   <= '0;
      mode_q <= MODE_RAMP;
      eoc_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      up_q  <= up_nxt;
      eoc_q <= eoc_nxt;
      if (load) begin
        rb_q   <= period_in;
        mode_q <= mode_in;
      end
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= rb_q); // R1
  AST_RAMP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && mode_q == MODE_RAMP && cnt_q == rb_q) |=> (cnt_q == '0)); // R1
  AST_CEN_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    (run && mode_q == MODE_CENTER && up_q && cnt_q == rb_q && rb_q != '0)
      |=> (!up_q || cnt_q == '0)); // R4
  AST_PERIOD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rb_q) |-> (cnt_q == '0)); // R11

endmodule

// File: rtl/pwm_phase.sv
module pwm_phase
  import pwm3_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         load,
  input  logic [W-1:0] cnt,
  input  logic         up,
  input  cnt_mode_e    mode,
  input  logic [W-1:0] start_in,
  input  logic [W-1:0] release_in,
  input  logic [W-1:0] second_in,
  input  logic         guard_in,
  input  logic         ena_in,
  input  logic         enb_in,
  output logic         a_q,
  output logic         b_q,
  output logic         sync_q
);

  logic [W-1:0] start_q, release_q, second_q;
  logic         guard_q, ena_q, enb_q;
  logic         win_a, win_b, b_guarded;
  logic         a_nxt, b_nxt, sync_nxt;
  logic [W:0]   cnt_p1;

  assign cnt_p1 = {1'b0, cnt} + 1'b1;

  // compare windows
  always_comb begin
    if (mode == MODE_CENTER) begin
      win_a = up ? (cnt < start_q) : (cnt <= start_q);
      win_b = up ? (cnt >= second_q) : (cnt_p1 >= {1'b0, second_q});
    end else begin
      win_a = (cnt > start_q) && (cnt <= release_q);
      win_b = (cnt > second_q);
    end
    b_guarded = win_b && !(guard_q && win_a);
    a_nxt     = run && win_a && ena_q;
    b_nxt     = run && b_guarded && enb_q;
    sync_nxt  = run && (mode == MODE_CENTER) && (cnt == release_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q   <= '0;
      release_q <= '0;
      second_q  <= '0;
      guard_q   <= 1'b0;
      ena_q     <= 1'b0;
      enb_q     <= 1'b0;
      a_q       <= 1'b0;
      b_q       <= 1'b0;
      sync_q    <= 1'b0;
    end else begin
      a_q    <= a_nxt;
      b_q    <= b_nxt;
      sync_q <= sync_nxt;
      if (load) begin
        start_q   <= start_in;
        release_q <= release_in;
        second_q  <= second_in;
        guard_q   <= guard_in;
        ena_q     <= ena_in;
        enb_q     <= enb_in;
      end
    end
  end

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    (a_q && b_q) |-> !$past(guard_q)); // R9
  AST_MASK_A: assert property (@(posedge clk) disable iff (!rst_n)
    a_q |-> $past(ena_q)); // R10
  AST_MASK_B: assert property (@(posedge clk) disable iff (!rst_n)
    b_q |-> $past(enb_q)); // R10
  AST_SYNC_CENTER: assert property (@(posedge clk) disable iff (!rst_n)
    sync_q |-> ($past(mode) == MODE_CENTER)); // R7

endmodule

// File: rtl/pwm3_bridge.sv
module pwm3_bridge
  import pwm3_pkg::*;
#(
  parameter int W    = 12,
  parameter int NMOD = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              centered_mode,
  input  logic [W-1:0]      period,
  input  logic [NMOD*W-1:0] start_thr,
  input  logic [NMOD*W-1:0] release_thr,
  input  logic [NMOD*W-1:0] second_thr,
  input  logic [NMOD-1:0]   guard_en,
  input  logic [2*NMOD-1:0] out_mask,
  output logic [NMOD-1:0]   pwm_a,
  output logic [NMOD-1:0]   pwm_b,
  output logic              cycle_end,
  output logic [NMOD-1:0]   sync_pulse
);

  logic [W-1:0] cnt;
  logic         up;
  cnt_mode_e    mode;
  logic         load;

  pwm_timebase #(.W(W)) u_tb (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .mode_in   (cnt_mode_e'(centered_mode)),
    .period_in (period),
    .cnt_q     (cnt),
    .up_q      (up),
    .mode_q    (mode),
    .load      (load),
    .eoc_q     (cycle_end)
  );

  for (genvar m = 0; m < NMOD; m++) begin : g_phase
    pwm_phase #(.W(W)) u_ph (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (run),
      .load       (load),
      .cnt        (cnt),
      .up         (up),
      .mode       (mode),
      .start_in   (start_thr[m*W +: W]),
      .release_in (release_thr[m*W +: W]),
      .second_in  (second_thr[m*W +: W]),
      .guard_in   (guard_en[m]),
      .ena_in     (out_mask[2*m]),
      .enb_in     (out_mask[2*m+1]),
      .a_q        (pwm_a[m]),
      .b_q        (pwm_b[m]),
      .sync_q     (sync_pulse[m])
    );
  end

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pwm_a == '0 && pwm_b == '0 && !cycle_end && sync_pulse == '0)); // R12

endmodule

// File: tb/pwm3_bridge_test.sv
module pwm3_bridge_test;
  localparam int W     = 12;
  localparam int NM    = 3;
  localparam time CLK_P = 10ns;

  logic clk = 1'b0;
  logic rst_n, run, cen;
  logic [W-1:0] per;
  logic [NM*W-1:0] sa_v, ra_v, sb_v;
  logic [NM-1:0] gd;
  logic [2*NM-1:0] msk;
  logic [NM-1:0] pa, pb, sy;
  logic eoc;

  pwm3_bridge #(.W(W), .NMOD(NM)) uut (
    .clk(clk), .rst_n(rst_n), .run(run), .centered_mode(cen), .period(per),
    .start_thr(sa_v), .release_thr(ra_v), .second_thr(sb_v), .guard_en(gd),
    .out_mask(msk), .pwm_a(pa), .pwm_b(pb), .cycle_end(eoc), .sync_pulse(sy)
  );

  always #(CLK_P/2) clk = ~clk;

  int vectors = 0, bad = 0, cyc = 0;
  string cur_req = "R12";
  bit live = 0;

  // reference model state
  int m_cnt, m_rb, m_sa[NM], m_ra[NM], m_sb[NM];
  bit m_up, m_cen, m_gd[NM], m_ea[NM], m_eb[NM];
  bit x_a[NM], x_b[NM], x_s[NM];
  bit x_eoc;

  function automatic void mload();
    m_rb = int'(per); m_cen = cen;
    for (int m = 0; m < NM; m++) begin
      m_sa[m] = int'(sa_v[m*W +: W]);
      m_ra[m] = int'(ra_v[m*W +: W]);
      m_sb[m] = int'(sb_v[m*W +: W]);
      m_gd[m] = gd[m];
      m_ea[m] = msk[2*m];
      m_eb[m] = msk[2*m+1];
    end
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_up = 1; m_rb = 0; m_cen = 0; x_eoc = 0;
      for (int m = 0; m < NM; m++) begin
        m_sa[m] = 0; m_ra[m] = 0; m_sb[m] = 0; m_gd[m] = 0; m_ea[m] = 0; m_eb[m] = 0;
        x_a[m] = 0; x_b[m] = 0; x_s[m] = 0;
      end
    end else if (!run) begin
      for (int m = 0; m < NM; m++) begin x_a[m] = 0; x_b[m] = 0; x_s[m] = 0; end
      x_eoc = 0; m_cnt = 0; m_up = 1;
      mload();
    end else begin
      int nc; bit nu;
      for (int m = 0; m < NM; m++) begin
        bit wa, wb; int lim;
        if (m_cen) begin
          lim = m_up ? m_sa[m] - 1 : m_sa[m];
          wa = (m_cnt <= lim);
          lim = m_up ? m_sb[m] : m_sb[m] - 1;
          wb = (m_cnt >= lim);
        end else begin
          wa = (m_sa[m] < m_cnt) && (m_cnt <= m_ra[m]);
          wb = (m_cnt > m_sb[m]);
        end
        if (m_gd[m] && wa) wb = 0;
        x_a[m] = wa && m_ea[m];
        x_b[m] = wb && m_eb[m];
        x_s[m] = m_cen && (m_cnt == m_ra[m]);
      end
      x_eoc = (m_cnt == m_rb);
      nu = m_up;
      if (!m_cen) begin nc = (m_cnt == m_rb) ? 0 : m_cnt + 1; nu = 1; end
      else if (m_up) begin
        if (m_cnt >= m_rb) begin nu = 0; nc = (m_cnt > 0) ? m_cnt - 1 : 0; end
        else nc = m_cnt + 1;
      end else nc = (m_cnt <= 1) ? 0 : m_cnt - 1;
      if (nc == 0) begin nu = 1; mload(); end
      m_cnt = nc; m_up = nu;
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (live) begin
      logic [NM-1:0] ea, eb, es;
      cyc++;
      for (int m = 0; m < NM; m++) begin ea[m] = x_a[m]; eb[m] = x_b[m]; es[m] = x_s[m]; end
      vectors++;
      if (pa !== ea || pb !== eb || sy !== es || eoc !== x_eoc) begin
        bad++;
        $display("FAIL %s cycle %0d: a=%b/%b b=%b/%b sync=%b/%b eoc=%b/%b (actual/expected)",
                 cur_req, cyc, pa, ea, pb, eb, sy, es, eoc, x_eoc);
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  int hi_a[NM], hi_b[NM], hi_ab[NM], hi_s[NM], hi_e;
  task automatic sample(input int n);
    for (int m = 0; m < NM; m++) begin hi_a[m] = 0; hi_b[m] = 0; hi_ab[m] = 0; hi_s[m] = 0; end
    hi_e = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      for (int m = 0; m < NM; m++) begin
        hi_a[m] += int'(pa[m]); hi_b[m] += int'(pb[m]);
        hi_ab[m] += int'(pa[m] & pb[m]); hi_s[m] += int'(sy[m]);
      end
      hi_e += int'(eoc);
    end
  endtask

  task automatic cfg(input int m, input int s, input int r, input int b);
    sa_v[m*W +: W] = W'(s); ra_v[m*W +: W] = W'(r); sb_v[m*W +: W] = W'(b);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_P*100000);
    bad++; vectors++;
    $display("FAIL R12 watchdog: run did not end (actual hung, expected finished)");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
    $finish;
  end

  initial begin
    rst_n = 0; run = 0; cen = 0; per = '0; sa_v = '0; ra_v = '0; sb_v = '0;
    gd = '0; msk = '0;
    live = 1;
    idle(3);
    cur_req = "R12";
    chk("R12 reset outputs", int'({pa, pb, sy, eoc}), 0);
    rst_n = 1;

    // ramp mode
    per = 20; msk = '1;
    cfg(0, 3, 8, 12); cfg(1, 5, 10, 7); cfg(2, 5, 10, 7); gd = 3'b100;
    idle(2);
    run = 1; cur_req = "R1";
    idle(45);
    sample(21);
    chk("R2 ramp A on-time", hi_a[0], 5);
    chk("R3 ramp B on-time", hi_b[0], 8);
    chk("R3 overlap unguarded", hi_ab[1], 3);
    chk("R9 overlap guarded", hi_ab[2], 0);
    chk("R9 guarded B on-time", hi_b[2], 10);
    chk("R8 ramp cycle_end per period", hi_e, 1);
    chk("R7 no sync in ramp", hi_s[0] + hi_s[1], 0);

    // mid-period changes: mask and thresholds deferred
    cur_req = "R11";
    idle(7);
    msk = 6'b110110; cfg(0, 30, 8, 12);
    idle(44);
    cur_req = "R10";
    sample(21);
    chk("R10 masked A0", hi_a[0], 0);
    chk("R10 masked B1", hi_b[1], 0);
    chk("R3 B0 still on", hi_b[0], 8);
    msk = '1;
    idle(44);
    sample(21);
    chk("R2 start above period keeps A low", hi_a[0], 0);

    // centred mode
    cur_req = "R4";
    cen = 1; per = 16;
    cfg(0, 4, 6, 10); cfg(1, 7, 16, 9); cfg(2, 3, 2, 5); gd = '0;
    idle(90);
    cur_req = "R5";
    sample(32);
    chk("R5 centred A0 on-time", hi_a[0], 8);
    chk("R6 centred B0 on-time", hi_b[0], 14);
    chk("R5 centred A1 on-time", hi_a[1], 14);
    chk("R6 centred B1 on-time", hi_b[1], 16);
    chk("R7 sync count", hi_s[0], 2);
    chk("R7 sync at turnaround", hi_s[1], 1);
    chk("R8 centred cycle_end per period", hi_e, 1);

    // stop
    cur_req = "R12";
    run = 0;
    idle(2);
    chk("R12 stopped outputs", int'({pa, pb, sy, eoc}), 0);
    idle(3);
    run = 1; cur_req = "R6";
    idle(40);

    live = 0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
    $finish;
  end
endmodule